// File: doc/BRIEF.md
# Dual-Mode Boot Control Unit

This unit decides, across chip resets, whether the system runs in a protected mode or a normal mode. A mode-state register holds the current mode. It can be changed only while a sticky lock bit is clear, and once boot code sets that bit the mode stays fixed until the next reset. The value the mode takes after a reset depends on the kind of reset. A cold reset takes the default from a boot-configuration input. A soft reset takes the value that software left in a separate next-mode register, which itself survives soft resets.

Software requests a mode change in two steps. It first writes the wanted mode into the next-mode register, then writes a reset request, and the unit answers with a fixed-length soft-reset pulse for the rest of the chip. Chip-unique key words pass through the unit and are exposed only while the mode is protected. They reach software over the register bus only on privileged reads.

Register word addresses: 0 = mode control, 1 = next mode, 2 = reset request, 3 = status, 4 and up = key words (one per address). Mode encoding: 0 = normal, 1 = protected.

Top module: `bootmode_ctrl`

## Requirements
- R1: After a cold reset is released, the first clock loads the mode from `boot_mode_i`. The status word then shows cold = 1 and lock = 0.
- R2: While unlocked, a privileged write to address 0 sets the mode from data bit 0. Writing data bit 1 as 1 sets the lock bit. Reading address 0 returns {lock, mode} in bits 1:0.
- R3: While locked, writes to address 0 leave the mode unchanged, and writing lock bit 1 as 0 does not clear the lock.
- R4: A clock with `soft_rst_i` high loads the mode from the next-mode register, clears the lock and clears the cold flag.
- R5: A privileged write to address 1 sets the next-mode register from data bit 0, readable at bit 0. The register keeps its value across soft resets and clears to normal (0) on a cold reset.
- R6: Writes with `bus_priv_i` low change neither the mode, the next-mode register nor the reset output.
- R7: A privileged write of 1 to address 2 drives `sreset_o` high for PULSE_CYCLES cycles, starting the cycle after the write. Requests made while the pulse is active are ignored and do not stretch it.
- R8: `key_words_o` equals `key_words_i` while the mode is protected and is all zero while it is normal.
- R9: A read at address 4+i returns key word i only when the mode is protected and `bus_priv_i` is high; otherwise it returns zero.
- R10: Address 3 reads status as bit 0 = mode, bit 1 = lock, bit 2 = cold flag (1 when the last reset was cold, 0 after a soft reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold_n | input | 1 | Cold reset, asynchronous assert, active low |
| soft_rst_i | input | 1 | Soft reset, synchronous, active high |
| boot_mode_i | input | 1 | Default mode applied after a cold reset |
| bus_addr_i | input | AW | Register word address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DW | Write data |
| bus_priv_i | input | 1 | Access is privileged |
| bus_rdata_o | output | DW | Read data for `bus_addr_i` (combinational) |
| key_words_i | input | KEY_WORDS*DW | Key words from storage |
| key_words_o | output | KEY_WORDS*DW | Key words gated by mode |
| sreset_o | output | 1 | Soft-reset request pulse |

## Verification
The assertions assume that `soft_rst_i` is synchronous to `clk` and that it rises only outside the cycle right after a cold reset is released. They also assume that a bus write is a one-cycle strobe with a stable address. The stimulus changes every input at the falling edge. It raises soft reset and bus writes for one cycle each, and it inserts at least one idle cycle after releasing cold reset before any other activity.

// File: rtl/bootmode_pkg.sv
package bootmode_pkg;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_PROT   = 1'b1
  } mode_e;

  localparam int ADDR_MODE     = 0;
  localparam int ADDR_NEXT     = 1;
  localparam int ADDR_RSTREQ   = 2;
  localparam int ADDR_STATUS   = 3;
  localparam int ADDR_KEY_BASE = 4;

  localparam int STAT_MODE_BIT = 0;
  localparam int STAT_LOCK_BIT = 1;
  localparam int STAT_COLD_BIT = 2;

endpackage

// File: rtl/bm_mode_state.sv
module bm_mode_state
  import bootmode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_cold_n,
  input  logic  soft_rst_i,
  input  logic  boot_mode_i,
  input  mode_e next_mode_i,
  input  logic  wr_i,
  input  logic  wr_mode_i,
  input  logic  wr_lock_i,
  output mode_e mode_o,
  output logic  lock_o,
  output logic  cold_o
);

  mode_e mode_q, mode_d;
  logic  lock_q, lock_d;
  logic  cold_q, cold_d;
  logic  pend_q, pend_d;
  logic  en;

  // next-state: soft reset wins, then the post-cold load, then bus writes
  always_comb begin
    mode_d = mode_q;
    lock_d = lock_q;
    cold_d = cold_q;
    pend_d = pend_q;
    if (soft_rst_i) begin
      mode_d = next_mode_i;
      lock_d = 1'b0;
      cold_d = 1'b0;
      pend_d = 1'b0;
    end else if (pend_q) begin
      mode_d = mode_e'(boot_mode_i);
      pend_d = 1'b0;
    end else if (wr_i) begin
      if (!lock_q)  mode_d = mode_e'(wr_mode_i);
      if (wr_lock_i) lock_d = 1'b1;
    end
  end

  assign en = soft_rst_i | pend_q | wr_i;

  always_ff @(posedge clk or negedge rst_cold_n) begin
    if (!rst_cold_n) begin
      mode_q <= MODE_NORMAL;
      lock_q <= 1'b0;
      cold_q <= 1'b1;
      pend_q <= 1'b1;
    end else if (en) begin
      mode_q <= mode_d;
      lock_q <= lock_d;
      cold_q <= cold_d;
      pend_q <= pend_d;
    end
  end

  assign mode_o = mode_q;
  assign lock_o = lock_q;
  assign cold_o = cold_q;

  // R1: first clock after cold release takes the boot default
  a_r1_cold_load: assert property (@(posedge clk) disable iff (!rst_cold_n)
    (pend_q && !soft_rst_i) |=> (mode_q == mode_e'($past(boot_mode_i))));

  // R3: a locked mode holds until a soft reset
  a_r3_locked_stable: assert property (@(posedge clk) disable iff (!rst_cold_n)
    (lock_q && !soft_rst_i) |=> ($stable(mode_q) && lock_q));

  // R4: soft reset takes the next-mode value and unlocks
  a_r4_soft_load: assert property (@(posedge clk) disable iff (!rst_cold_n)
    soft_rst_i |=> (!lock_q && !cold_q && mode_q == $past(next_mode_i)));

endmodule

// File: rtl/bm_next_reg.sv
module bm_next_reg
  import bootmode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_cold_n,
  input  logic  wr_i,
  input  logic  wr_val_i,
  output mode_e next_o
);

  mode_e next_q, next_d;

  always_comb begin
    next_d = mode_e'(wr_val_i);
  end

  always_ff @(posedge clk or negedge rst_cold_n) begin
    if (!rst_cold_n) begin
      next_q <= MODE_NORMAL;
    end else if (wr_i) begin
      next_q <= next_d;
    end
  end

  assign next_o = next_q;

  // R5: only a write strobe changes the next-mode value
  a_r5_next_hold: assert property (@(posedge clk) disable iff (!rst_cold_n)
    !wr_i |=> $stable(next_q));

endmodule

// File: rtl/bm_rst_pulse.sv
module bm_rst_pulse #(
  parameter int PULSE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_cold_n,
  input  logic req_i,
  output logic busy_o
);

  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end else if (req_i) begin
      cnt_d = CNT_W'(PULSE_CYCLES);
    end
  end

  assign en = (cnt_q != '0) | req_i;

  always_ff @(posedge clk or negedge rst_cold_n) begin
    if (!rst_cold_n) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (cnt_q != '0);

  // R7: pulse stays high until the count runs out
  a_r7_pulse_hold: assert property (@(posedge clk) disable iff (!rst_cold_n)
    (cnt_q > CNT_W'(1)) |=> busy_o);

  // R7: a request during the pulse does not restart it
  a_r7_no_retrig: assert property (@(posedge clk) disable iff (!rst_cold_n)
    (busy_o && req_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R7: an accepted request raises the pulse on the next cycle
  a_r7_start: assert property (@(posedge clk) disable iff (!rst_cold_n)
    (!busy_o && req_i) |=> busy_o);

endmodule

// File: rtl/bm_key_gate.sv
module bm_key_gate
  import bootmode_pkg::*;
#(
  parameter int KEY_WORDS = 4,
  parameter int KEY_W     = 32,
  localparam int IDX_W    = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1
) (
  input  mode_e                      mode_i,
  input  logic [KEY_WORDS*KEY_W-1:0] key_i,
  output logic [KEY_WORDS*KEY_W-1:0] key_o,
  input  logic [IDX_W-1:0]           sel_i,
  input  logic                       rd_ok_i,
  output logic [KEY_W-1:0]           word_o
);

  logic prot;
  assign prot = (mode_i == MODE_PROT);

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
    assign key_o[g*KEY_W +: KEY_W] = prot ? key_i[g*KEY_W +: KEY_W] : '0;
  end

  always_comb begin
    word_o = '0;
    if (prot && rd_ok_i && (int'(sel_i) < KEY_WORDS)) begin
      word_o = key_i[sel_i*KEY_W +: KEY_W];
    end
  end

endmodule

// File: rtl/bootmode_ctrl.sv
module bootmode_ctrl
  import bootmode_pkg::*;
#(
  parameter int AW           = 4,
  parameter int DW           = 32,
  parameter int KEY_WORDS    = 4,
  parameter int PULSE_CYCLES = 8
) (
  input  logic                   clk,
  input  logic                   rst_cold_n,
  input  logic                   soft_rst_i,
  input  logic                   boot_mode_i,
  input  logic [AW-1:0]          bus_addr_i,
  input  logic                   bus_we_i,
  input  logic [DW-1:0]          bus_wdata_i,
  input  logic                   bus_priv_i,
  output logic [DW-1:0]          bus_rdata_o,
  input  logic [KEY_WORDS*DW-1:0] key_words_i,
  output logic [KEY_WORDS*DW-1:0] key_words_o,
  output logic                   sreset_o
);

  localparam int IDX_W = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;

  mode_e mode, next_mode;
  logic  lock, cold;
  logic  wr_ok;
  logic  hit_mode, hit_next, hit_req, hit_stat, hit_key;
  logic  [AW-1:0]    key_off;
  logic  [IDX_W-1:0] key_idx;
  logic  [DW-1:0]    key_word;

  // address decode
  assign hit_mode = (bus_addr_i == AW'(ADDR_MODE));
  assign hit_next = (bus_addr_i == AW'(ADDR_NEXT));
  assign hit_req  = (bus_addr_i == AW'(ADDR_RSTREQ));
  assign hit_stat = (bus_addr_i == AW'(ADDR_STATUS));
  assign hit_key  = (int'(bus_addr_i) >= ADDR_KEY_BASE) &&
                    (int'(bus_addr_i) <  ADDR_KEY_BASE + KEY_WORDS);
  assign key_off  = bus_addr_i - AW'(ADDR_KEY_BASE);
  assign key_idx  = key_off[IDX_W-1:0];

  assign wr_ok = bus_we_i & bus_priv_i;

  bm_mode_state u_mode (
    .clk         (clk),
    .rst_cold_n  (rst_cold_n),
    .soft_rst_i  (soft_rst_i),
    .boot_mode_i (boot_mode_i),
    .next_mode_i (next_mode),
    .wr_i        (wr_ok & hit_mode),
    .wr_mode_i   (bus_wdata_i[0]),
    .wr_lock_i   (bus_wdata_i[1]),
    .mode_o      (mode),
    .lock_o      (lock),
    .cold_o      (cold)
  );

  bm_next_reg u_next (
    .clk        (clk),
    .rst_cold_n (rst_cold_n),
    .wr_i       (wr_ok & hit_next),
    .wr_val_i   (bus_wdata_i[0]),
    .next_o     (next_mode)
  );

  bm_rst_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk        (clk),
    .rst_cold_n (rst_cold_n),
    .req_i      (wr_ok & hit_req & bus_wdata_i[0]),
    .busy_o     (sreset_o)
  );

  bm_key_gate #(.KEY_WORDS(KEY_WORDS), .KEY_W(DW)) u_key (
    .mode_i  (mode),
    .key_i   (key_words_i),
    .key_o   (key_words_o),
    .sel_i   (key_idx),
    .rd_ok_i (bus_priv_i & hit_key),
    .word_o  (key_word)
  );

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (hit_mode) begin
      bus_rdata_o[0] = mode;
      bus_rdata_o[1] = lock;
    end else if (hit_next) begin
      bus_rdata_o[0] = next_mode;
    end else if (hit_stat) begin
      bus_rdata_o[STAT_MODE_BIT] = mode;
      bus_rdata_o[STAT_LOCK_BIT] = lock;
      bus_rdata_o[STAT_COLD_BIT] = cold;
    end else if (hit_key) begin
      bus_rdata_o = key_word;
    end
  end

  // R6: unprivileged writes leave the next-mode register alone
  a_r6_unpriv_next: assert property (@(posedge clk) disable iff (!rst_cold_n)
    (bus_we_i && !bus_priv_i) |=> $stable(next_mode));

  // R8: key output is blank whenever the mode is normal
  a_r8_key_blank: assert property (@(posedge clk) disable iff (!rst_cold_n)
    (mode == MODE_NORMAL) |-> (key_words_o == '0));

  // R9: unprivileged key reads return zero
  a_r9_unpriv_key: assert property (@(posedge clk) disable iff (!rst_cold_n)
    (hit_key && !bus_priv_i) |-> (bus_rdata_o == '0));

endmodule

// File: tb/test_bootmode_ctrl.sv
module test_bootmode_ctrl;

  localparam int AW = 4;
  localparam int DW = 32;
  localparam int KW = 4;
  localparam int PC = 8;

  logic              clk = 1'b0;
  logic              rst_cold_n = 1'b0;
  logic              soft_rst_i = 1'b0;
  logic              boot_mode_i = 1'b1;
  logic [AW-1:0]     bus_addr_i = '0;
  logic              bus_we_i = 1'b0;
  logic [DW-1:0]     bus_wdata_i = '0;
  logic              bus_priv_i = 1'b0;
  logic [DW-1:0]     bus_rdata_o;
  logic [KW*DW-1:0]  key_words_i;
  logic [KW*DW-1:0]  key_words_o;
  logic              sreset_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  for (genvar g = 0; g < KW; g++) begin : g_key
    assign key_words_i[g*DW +: DW] = 32'hC3A50000 + g;
  end

  bootmode_ctrl #(.AW(AW), .DW(DW), .KEY_WORDS(KW), .PULSE_CYCLES(PC)) i_bootmode_ctrl (
    .clk(clk), .rst_cold_n(rst_cold_n), .soft_rst_i(soft_rst_i),
    .boot_mode_i(boot_mode_i), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
    .bus_wdata_i(bus_wdata_i), .bus_priv_i(bus_priv_i), .bus_rdata_o(bus_rdata_o),
    .key_words_i(key_words_i), .key_words_o(key_words_o), .sreset_o(sreset_o)
  );

  // scoreboard: kind 0 = read data, 1 = sreset_o, 2 = key output word 0
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always @(negedge clk) begin
    #2;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = bus_rdata_o;
        1: act = {31'd0, sreset_o};
        default: act = key_words_o[31:0];
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic rd_chk(input int addr, input bit priv, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr_i = AW'(addr);
    bus_priv_i = priv;
    sb_q.push_back('{0, exp, tag});
  endtask

  task automatic sig_chk(input int kind, input logic [31:0] exp, input string tag);
    @(negedge clk);
    sb_q.push_back('{kind, exp, tag});
  endtask

  task automatic bus_wr(input int addr, input logic [31:0] data, input bit priv);
    @(negedge clk);
    bus_addr_i = AW'(addr);
    bus_wdata_i = data;
    bus_priv_i = priv;
    bus_we_i = 1'b1;
    @(negedge clk);
    bus_we_i = 1'b0;
    bus_wdata_i = '0;
  endtask

  task automatic soft_rst();
    @(negedge clk);
    soft_rst_i = 1'b1;
    @(negedge clk);
    soft_rst_i = 1'b0;
  endtask

  task automatic cold_rst(input bit dflt);
    @(negedge clk);
    rst_cold_n = 1'b0;
    boot_mode_i = dflt;
    @(negedge clk);
    rst_cold_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_cold_n = 1'b1;
    // R1 / R10: cold boot into protected by default
    rd_chk(3, 1, 32'h5, "R1 R10 status after cold boot");
    rd_chk(1, 1, 32'h0, "R5 next mode after cold boot");
    sig_chk(2, 32'hC3A50000, "R8 key out in protected");
    rd_chk(5, 1, 32'hC3A50001, "R9 privileged key read");
    rd_chk(6, 0, 32'h0, "R9 unprivileged key read");
    // R2: unlocked write to normal
    bus_wr(0, 32'h0, 1);
    rd_chk(0, 1, 32'h0, "R2 mode written normal");
    sig_chk(2, 32'h0, "R8 key out blank in normal");
    rd_chk(4, 1, 32'h0, "R9 key read in normal");
    // R6: unprivileged mode write ignored
    bus_wr(0, 32'h1, 0);
    rd_chk(0, 1, 32'h0, "R6 unprivileged mode write");
    // R2: set mode and lock together
    bus_wr(0, 32'h3, 1);
    rd_chk(3, 1, 32'h7, "R2 R10 mode and lock set");
    // R3: locked writes have no effect
    bus_wr(0, 32'h0, 1);
    rd_chk(0, 1, 32'h3, "R3 locked write ignored");
    // R6: unprivileged next-mode write
    bus_wr(1, 32'h1, 0);
    rd_chk(1, 1, 32'h0, "R6 unprivileged next write");
    // R4: soft reset into normal
    soft_rst();
    rd_chk(3, 1, 32'h0, "R4 R10 soft reset to normal");
    // R5 / R4: request protected next
    bus_wr(1, 32'h1, 1);
    rd_chk(1, 1, 32'h1, "R5 next mode written");
    soft_rst();
    rd_chk(3, 1, 32'h1, "R4 soft reset to protected");
    rd_chk(1, 1, 32'h1, "R5 next kept over soft reset");
    // R7: pulse length and no retrigger
    bus_wr(2, 32'h1, 1);
    bus_wr(2, 32'h1, 1);
    for (int i = 0; i < 5; i++) sig_chk(1, 32'h1, "R7 pulse high");
    sig_chk(1, 32'h0, "R7 pulse ended, not stretched");
    // R6: unprivileged reset request
    bus_wr(2, 32'h1, 0);
    sig_chk(1, 32'h0, "R6 unprivileged reset request");
    // R1 / R5: cold reset to normal default
    cold_rst(1'b0);
    rd_chk(3, 1, 32'h4, "R1 R10 status after cold normal");
    rd_chk(1, 1, 32'h0, "R5 next cleared by cold reset");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule